// File: doc/BRIEF.md
# Dual-Slot Serial Audio Port

This block moves 16-bit audio samples between a codec's converter side and a four-wire serial link made of a bit clock, a frame sync, a serial input and a serial output. Each frame lasts 32 bit-clock periods and is split into two 16-bit slots. A configuration bit selects one slot. In that slot the capture sample from the converter side is shifted out, and a playback sample is shifted in and handed to the converter side as a parallel word with a one-cycle strobe.

The port runs in one of two timing roles. As a follower, it takes the bit clock and frame sync from outside, and it accepts either a one-bit sync pulse or a half-frame sync level. As the timing source, it divides its system clock (the codec master clock) by 8, 16 or 32 to make the bit clock, and it drives a half-frame sync. A loopback option sends the capture word straight to the playback word, bypassing the serial input. All logic runs on the system clock. The external bit clock and frame sync are assumed to be synchronous to it and much slower. Configuration is meant to be changed only while reset is held.

Top module: `sap_port`

## Requirements
- R1: While reset is high and in the first cycle after it, sdo, bclk_out, fsync_out, dac_valid and frame_err are 0. The configuration in effect after reset is follower timing, short sync, slot 0, no loopback, divide factor 1.
- R2: In follower mode with cfg_long_fs=0, the sync is a pulse one bit period wide. The bit period that follows it is bit 0, and a frame then lasts 32 bit periods.
- R3: In follower mode with cfg_long_fs=1, bit 0 is the bit period at whose bit-clock rising edge fsync_in is first seen high.
- R4: cfg_slot=0 selects bits 0–15 and cfg_slot=1 selects bits 16–31. sdo sends adc_data MSB first, changing after the bit-clock rise, and is 0 in the other slot.
- R5: sdi is sampled at each bit-clock fall inside the selected slot, MSB first. One system-clock cycle after the last bit's fall, dac_valid is high for exactly one cycle with the word on dac_data.
- R6: In timing-source mode, bclk_out has a period of 8, 16 or 32 system clocks for cfg_div 0, 1 and 2 or 3 respectively. In follower mode, bclk_out and fsync_out stay 0.
- R7: In timing-source mode, fsync_out is high for bits 0–15 and low for bits 16–31, whatever cfg_long_fs says.
- R8: With cfg_loopback=1, each dac_data word equals adc_data, and sdi has no effect on it.
- R9: In follower mode, a sync that starts a frame other than after bit 31 sets frame_err, and the counter restarts at bit 0 from that sync. frame_err stays set until reset and is never set in timing-source mode.
- R10: In follower mode, before the first sync after reset, sdo stays 0 and no dac_valid is produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System (master) clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_master | input | 1 | 1 = port generates bit clock and sync |
| cfg_long_fs | input | 1 | Follower sync style: 1 = half-frame level, 0 = one-bit pulse |
| cfg_slot | input | 1 | Active slot: 0 = bits 0–15, 1 = bits 16–31 |
| cfg_loopback | input | 1 | Route adc_data to dac_data |
| cfg_div | input | 2 | Clock divide factor select: 0 = 1, 1 = 2, 2/3 = 4 |
| bclk_in | input | 1 | Bit clock from outside (follower mode) |
| fsync_in | input | 1 | Frame sync from outside (follower mode) |
| sdi | input | 1 | Serial playback data in |
| bclk_out | output | 1 | Generated bit clock (timing-source mode) |
| fsync_out | output | 1 | Generated frame sync (timing-source mode) |
| sdo | output | 1 | Serial capture data out |
| adc_data | input | 16 | Capture sample from converter side |
| dac_data | output | 16 | Playback sample to converter side |
| dac_valid | output | 1 | One-cycle strobe for dac_data |
| frame_err | output | 1 | Sticky misplaced-sync flag |

## Verification
Each sdo bit is registered in the system-clock cycle that detects the bit-clock rise, so it is valid one cycle after that rise. The bench samples it just before it drives the following fall. dac_valid and dac_data appear one cycle after the cycle that sees the fall of the slot's last bit. A scoreboard queue pops an expected word only when the strobe arrives, and it flags any strobe that has no expected word behind it. In timing-source mode, fsync_out and sdo follow bclk_out's rise by one cycle, so the bench waits an extra cycle after it sees the rise before it reads fsync_out. Periods are counted in whole system-clock cycles between observed rises.

// File: rtl/sap_pkg.sv
package sap_pkg;

  typedef enum logic [1:0] {
    DIV_1  = 2'd0,
    DIV_2  = 2'd1,
    DIV_4  = 2'd2,
    DIV_4B = 2'd3
  } div_sel_e;

  typedef struct packed {
    logic     master;
    logic     long_fs;
    logic     slot;
    logic     loopback;
    div_sel_e div;
  } sap_cfg_t;

  localparam sap_cfg_t CFG_RESET = '{
    master:   1'b0,
    long_fs:  1'b0,
    slot:     1'b0,
    loopback: 1'b0,
    div:      DIV_1
  };

  // log2 of the divide factor selected by the two-bit code
  function automatic int unsigned div_shift(input div_sel_e d);
    case (d)
      DIV_1:   return 0;
      DIV_2:   return 1;
      default: return 2;
    endcase
  endfunction

endpackage

// File: rtl/sap_bclk_gen.sv
module sap_bclk_gen
  import sap_pkg::*;
#(
  parameter int BASE_HALF = 4
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     master,
  input  div_sel_e div,
  input  logic     bclk_in,
  output logic     bclk_gen,
  output logic     rise,
  output logic     fall
);

  localparam int MAX_HALF = BASE_HALF * 4;
  localparam int PC_W     = $clog2(MAX_HALF) + 1;

  logic [PC_W-1:0] pc;
  logic [PC_W-1:0] half_m1;
  logic            bclk_eff;
  logic            bclk_q;

  always_comb begin
    half_m1 = PC_W'((BASE_HALF << div_shift(div)) - 1);
  end

  // half-period counter: the generated bit clock toggles every half_m1+1 clocks
  always_ff @(posedge clk) begin
    if (rst || !master) begin
      pc       <= '0;
      bclk_gen <= 1'b0;
    end else if (pc == half_m1) begin
      pc       <= '0;
      bclk_gen <= ~bclk_gen;
    end else begin
      pc <= pc + PC_W'(1);
    end
  end

  assign bclk_eff = master ? bclk_gen : bclk_in;

  always_ff @(posedge clk) begin
    if (rst) bclk_q <= 1'b0;
    else     bclk_q <= bclk_eff;
  end

  assign rise = bclk_eff & ~bclk_q;
  assign fall = ~bclk_eff & bclk_q;

endmodule

// File: rtl/sap_framer.sv
module sap_framer #(
  parameter int FRAME_BITS = 32,
  parameter int CW         = $clog2(FRAME_BITS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          master,
  input  logic          long_fs,
  input  logic          fsync_in,
  input  logic          rise,
  output logic [CW-1:0] bcnt,
  output logic [CW-1:0] nxt,
  output logic          sync_hit,
  output logic          locked,
  output logic          frame_err,
  output logic          fs_gen
);

  logic fs_r;

  // follower sync detection at each bit-clock rise
  always_comb begin
    if (master)       sync_hit = 1'b0;
    else if (long_fs) sync_hit = fsync_in & ~fs_r;
    else              sync_hit = fs_r;
  end

  always_comb begin
    if (sync_hit)              nxt = '0;
    else if (locked || master) nxt = bcnt + CW'(1);
    else                       nxt = bcnt;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bcnt      <= '1;
      fs_r      <= 1'b0;
      locked    <= 1'b0;
      frame_err <= 1'b0;
      fs_gen    <= 1'b0;
    end else begin
      if (!master) fs_gen <= 1'b0;
      if (rise) begin
        fs_r <= fsync_in;
        bcnt <= nxt;
        if (sync_hit) begin
          locked <= 1'b1;
          if (locked && (bcnt != '1)) frame_err <= 1'b1;
        end
        if (master) fs_gen <= ~nxt[CW-1];
      end
    end
  end

endmodule

// File: rtl/sap_datapath.sv
module sap_datapath #(
  parameter int W  = 16,
  parameter int CW = $clog2(2 * W)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rise,
  input  logic          fall,
  input  logic          act_rise,
  input  logic          act_fall,
  input  logic [CW-1:0] nxt,
  input  logic [CW-1:0] bcnt,
  input  logic          slot,
  input  logic          loopback,
  input  logic [W-1:0]  adc_data,
  input  logic          sdi,
  output logic          sdo,
  output logic [W-1:0]  dac_data,
  output logic          dac_valid
);

  logic [W-1:0]    tx_hold;
  logic [W-1:0]    rx_sh;
  logic [CW-2:0]   idx_n;
  logic            slot_n;
  logic            slot_c;
  logic [W-1:0]    rx_word;

  assign idx_n   = nxt[CW-2:0];
  assign slot_n  = act_rise && (nxt[CW-1] == slot);
  assign slot_c  = act_fall && (bcnt[CW-1] == slot);
  assign rx_word = {rx_sh[W-2:0], sdi};

  // transmit: drive one bit per rise, MSB first
  always_ff @(posedge clk) begin
    if (rst) begin
      sdo     <= 1'b0;
      tx_hold <= '0;
    end else if (rise) begin
      if (slot_n) begin
        if (idx_n == '0) begin
          tx_hold <= adc_data;
          sdo     <= adc_data[W-1];
        end else begin
          sdo <= tx_hold[~idx_n];
        end
      end else begin
        sdo <= 1'b0;
      end
    end
  end

  // receive: shift one bit per fall, present word after the last one
  always_ff @(posedge clk) begin
    if (rst) begin
      rx_sh     <= '0;
      dac_data  <= '0;
      dac_valid <= 1'b0;
    end else begin
      dac_valid <= 1'b0;
      if (fall && slot_c) begin
        rx_sh <= rx_word;
        if (bcnt[CW-2:0] == '1) begin
          dac_valid <= 1'b1;
          dac_data  <= loopback ? adc_data : rx_word;
        end
      end
    end
  end

endmodule

// File: rtl/sap_port.sv
module sap_port
  import sap_pkg::*;
#(
  parameter int SAMPLE_W  = 16,
  parameter int BASE_HALF = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                cfg_master,
  input  logic                cfg_long_fs,
  input  logic                cfg_slot,
  input  logic                cfg_loopback,
  input  logic [1:0]          cfg_div,
  input  logic                bclk_in,
  input  logic                fsync_in,
  input  logic                sdi,
  output logic                bclk_out,
  output logic                fsync_out,
  output logic                sdo,
  input  logic [SAMPLE_W-1:0] adc_data,
  output logic [SAMPLE_W-1:0] dac_data,
  output logic                dac_valid,
  output logic                frame_err
);

  localparam int FRAME_BITS = 2 * SAMPLE_W;
  localparam int CNT_W      = $clog2(FRAME_BITS);

  sap_cfg_t         cfg_q;
  logic             mode_master;
  logic             rise;
  logic             fall;
  logic [CNT_W-1:0] bcnt;
  logic [CNT_W-1:0] nxt;
  logic             sync_hit;
  logic             locked;
  logic             act_rise;
  logic             act_fall;

  always_ff @(posedge clk) begin
    if (rst) cfg_q <= CFG_RESET;
    else     cfg_q <= '{master:   cfg_master,
                        long_fs:  cfg_long_fs,
                        slot:     cfg_slot,
                        loopback: cfg_loopback,
                        div:      div_sel_e'(cfg_div)};
  end

  assign mode_master = cfg_q.master;
  assign act_rise    = mode_master | locked | sync_hit;
  assign act_fall    = mode_master | locked;

  sap_bclk_gen #(
    .BASE_HALF (BASE_HALF)
  ) u_bclk (
    .clk      (clk),
    .rst      (rst),
    .master   (mode_master),
    .div      (cfg_q.div),
    .bclk_in  (bclk_in),
    .bclk_gen (bclk_out),
    .rise     (rise),
    .fall     (fall)
  );

  sap_framer #(
    .FRAME_BITS (FRAME_BITS),
    .CW         (CNT_W)
  ) u_framer (
    .clk       (clk),
    .rst       (rst),
    .master    (mode_master),
    .long_fs   (cfg_q.long_fs),
    .fsync_in  (fsync_in),
    .rise      (rise),
    .bcnt      (bcnt),
    .nxt       (nxt),
    .sync_hit  (sync_hit),
    .locked    (locked),
    .frame_err (frame_err),
    .fs_gen    (fsync_out)
  );

  sap_datapath #(
    .W  (SAMPLE_W),
    .CW (CNT_W)
  ) u_data (
    .clk       (clk),
    .rst       (rst),
    .rise      (rise),
    .fall      (fall),
    .act_rise  (act_rise),
    .act_fall  (act_fall),
    .nxt       (nxt),
    .bcnt      (bcnt),
    .slot      (cfg_q.slot),
    .loopback  (cfg_q.loopback),
    .adc_data  (adc_data),
    .sdi       (sdi),
    .sdo       (sdo),
    .dac_data  (dac_data),
    .dac_valid (dac_valid)
  );

endmodule

// File: rtl/sap_port_chk.sv
module sap_port_chk (
  input logic clk,
  input logic rst,
  input logic mode_master,
  input logic locked,
  input logic sdo,
  input logic dac_valid,
  input logic frame_err,
  input logic bclk_out,
  input logic fsync_out
);

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!sdo && !dac_valid && !frame_err && !bclk_out && !fsync_out)); // R1

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    dac_valid |=> !dac_valid); // R5

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    frame_err |=> frame_err); // R9

  AST_MASTER_NO_ERR: assert property (@(posedge clk) disable iff (rst)
    (mode_master && !frame_err) |=> !frame_err); // R9

  AST_FOLLOWER_NO_CLK_OUT: assert property (@(posedge clk) disable iff (rst)
    !mode_master |=> (!bclk_out && !fsync_out)); // R6

  AST_UNLOCKED_SILENT: assert property (@(posedge clk) disable iff (rst)
    (!mode_master && !locked) |-> (!sdo && !dac_valid)); // R10

endmodule

bind sap_port sap_port_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .mode_master (mode_master),
  .locked      (locked),
  .sdo         (sdo),
  .dac_valid   (dac_valid),
  .frame_err   (frame_err),
  .bclk_out    (bclk_out),
  .fsync_out   (fsync_out)
);

// File: tb/sap_port_bench.sv
module sap_port_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_master = 1'b0, cfg_long_fs = 1'b0, cfg_slot = 1'b0, cfg_loopback = 1'b0;
  logic [1:0]  cfg_div = 2'd0;
  logic        bclk_in = 1'b0, fsync_in = 1'b0, sdi = 1'b0;
  logic        bclk_out, fsync_out, sdo, dac_valid, frame_err;
  logic [15:0] adc_data = '0;
  logic [15:0] dac_data;

  int          checks = 0;
  int          errors = 0;
  logic        mon_en = 1'b1;
  logic [15:0] exp_q[$];
  string       tag_q[$];
  logic [15:0] exp_w;
  string       exp_t;

  always #5 clk = ~clk;

  sap_port u_sap_port (
    .clk(clk), .rst(rst), .cfg_master(cfg_master), .cfg_long_fs(cfg_long_fs),
    .cfg_slot(cfg_slot), .cfg_loopback(cfg_loopback), .cfg_div(cfg_div),
    .bclk_in(bclk_in), .fsync_in(fsync_in), .sdi(sdi), .bclk_out(bclk_out),
    .fsync_out(fsync_out), .sdo(sdo), .adc_data(adc_data), .dac_data(dac_data),
    .dac_valid(dac_valid), .frame_err(frame_err)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && mon_en && dac_valid) begin
      if (exp_q.size() == 0) begin
        checks++;
        errors++;
        $display("FAIL R10 unexpected dac_valid actual=%0h expected=none", dac_data);
      end else begin
        exp_w = exp_q.pop_front();
        exp_t = tag_q.pop_front();
        check(dac_data == exp_w, exp_t, dac_data, exp_w);
      end
    end
  end

  task automatic do_reset(input logic m, input logic lfs, input logic sl,
                          input logic lb, input logic [1:0] dv);
    @(negedge clk);
    rst = 1'b1; bclk_in = 1'b0; fsync_in = 1'b0; sdi = 1'b0;
    cfg_master = m; cfg_long_fs = lfs; cfg_slot = sl; cfg_loopback = lb; cfg_div = dv;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  // one follower bit period: 4 clocks high, 4 low
  task automatic sbit(input logic fs, input logic d, output logic so);
    @(negedge clk);
    bclk_in = 1'b1; fsync_in = fs; sdi = d;
    repeat (3) @(negedge clk);
    @(negedge clk);
    so = sdo;
    bclk_in = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic push_exp(input logic [15:0] rxw, input logic [15:0] adc);
    exp_q.push_back(cfg_loopback ? adc : rxw);
    tag_q.push_back(cfg_loopback ? "R8 loopback dac_data" : "R5 dac_data");
  endtask

  task automatic sframe(input logic [15:0] rxw, input logic [15:0] adc, input string tag);
    logic [15:0] got;
    logic        so;
    int          stray;
    got = '0; stray = 0;
    adc_data = adc;
    push_exp(rxw, adc);
    for (int b = 0; b < 32; b++) begin
      logic fs;
      logic in_slot;
      fs = cfg_long_fs ? (b < 16) : (b == 31);
      in_slot = (b / 16) == int'(cfg_slot);
      sbit(fs, in_slot ? rxw[15 - (b % 16)] : 1'b0, so);
      if (in_slot) got = {got[14:0], so};
      else if (so) stray++;
    end
    check(got == adc, {tag, " sdo word"}, got, adc);
    check(stray == 0, "R4 sdo zero outside slot", stray, 0);
  endtask

  task automatic wait_bclk(input logic v);
    do @(negedge clk); while (bclk_out !== v);
  endtask

  task automatic mframe(input logic [15:0] rxw, input logic [15:0] adc);
    logic        fs, prev;
    logic [15:0] got;
    int          fs_cnt, first_ok;
    adc_data = adc; sdi = 1'b0; prev = 1'b1; got = '0; fs_cnt = 0; first_ok = 1;
    mon_en = 1'b0;
    forever begin
      wait_bclk(0); wait_bclk(1); @(negedge clk);
      fs = fsync_out;
      if (fs && !prev) break;
      prev = fs;
    end
    mon_en = 1'b1;
    push_exp(rxw, adc);
    for (int b = 0; b < 32; b++) begin
      logic in_slot;
      if (b > 0) begin
        wait_bclk(0); wait_bclk(1); @(negedge clk);
        fs = fsync_out;
      end
      if (fs) fs_cnt++;
      if (fs != (b < 16)) first_ok = 0;
      in_slot = (b / 16) == int'(cfg_slot);
      sdi = in_slot ? rxw[15 - (b % 16)] : 1'b0;
      wait_bclk(0);
      if (in_slot) got = {got[14:0], sdo};
    end
    repeat (3) @(negedge clk);
    mon_en = 1'b0;
    check(fs_cnt == 16, "R7 fsync_out high bit count", fs_cnt, 16);
    check(first_ok == 1, "R7 fsync_out high on bits 0-15 only", first_ok, 1);
    check(got == adc, "R4 master sdo word", got, adc);
    check(exp_q.size() == 0, "R5 master word delivered", exp_q.size(), 0);
    check(frame_err == 1'b0, "R9 no error in master", frame_err, 0);
  endtask

  task automatic measure(input logic [1:0] dv, input int expect_p);
    int n;
    do_reset(1'b1, 1'b0, 1'b0, 1'b0, dv);
    mon_en = 1'b0;
    wait_bclk(0); wait_bclk(1);
    n = 0;
    do begin @(negedge clk); n++; end while (bclk_out !== 1'b0);
    do begin @(negedge clk); n++; end while (bclk_out !== 1'b1);
    check(n == expect_p, "R6 bclk_out period", n, expect_p);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : stim
    logic so;
    int   stray;
    // R1: reset state
    repeat (2) @(negedge clk);
    check(sdo == 0 && bclk_out == 0 && fsync_out == 0, "R1 outputs in reset",
          {sdo, bclk_out, fsync_out}, 0);
    check(dac_valid == 0 && frame_err == 0, "R1 status in reset", {dac_valid, frame_err}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(sdo == 0 && frame_err == 0 && dac_valid == 0, "R1 after release",
          {sdo, frame_err, dac_valid}, 0);

    // R10: no activity before the first sync (default follower, short sync)
    stray = 0;
    adc_data = 16'hFFFF;
    for (int i = 0; i < 20; i++) begin
      sbit(1'b0, 1'b1, so);
      if (so) stray++;
    end
    check(stray == 0, "R10 sdo before sync", stray, 0);
    check(bclk_out == 0 && fsync_out == 0, "R6 follower outputs quiet", {bclk_out, fsync_out}, 0);

    // R2: short-sync frames, slot 0
    sbit(1'b1, 1'b0, so);
    sframe(16'hA5C3, 16'h1234, "R2 sfs slot0");
    sframe(16'h0001, 16'h8000, "R2 sfs slot0");
    sframe(16'hFFFF, 16'h7FFE, "R2 sfs slot0");
    check(frame_err == 0, "R2 no error on regular frames", frame_err, 0);

    // R9: early sync at bit 10, then resync
    for (int b = 0; b <= 10; b++) sbit(b == 10, 1'b0, so);
    sframe(16'h5A5A, 16'hC001, "R9 resync");
    check(frame_err == 1, "R9 error set", frame_err, 1);
    sframe(16'h0F0F, 16'h3C3C, "R9 after error");
    check(frame_err == 1, "R9 error sticky", frame_err, 1);
    check(exp_q.size() == 0, "R5 all words delivered", exp_q.size(), 0);

    // R4: short sync, slot 1
    do_reset(1'b0, 1'b0, 1'b1, 1'b0, 2'd0);
    sbit(1'b1, 1'b0, so);
    sframe(16'hBEEF, 16'hCAFE, "R4 slot1");
    sframe(16'h1357, 16'h2468, "R4 slot1");

    // R3: long sync, slot 0 and slot 1
    do_reset(1'b0, 1'b1, 1'b0, 1'b0, 2'd0);
    sbit(1'b0, 1'b0, so);
    sframe(16'h8421, 16'h4812, "R3 lfs slot0");
    sframe(16'h7777, 16'h9999, "R3 lfs slot0");
    check(frame_err == 0, "R3 no error", frame_err, 0);
    do_reset(1'b0, 1'b1, 1'b1, 1'b0, 2'd0);
    sbit(1'b0, 1'b0, so);
    sframe(16'h0FF0, 16'hF00F, "R3 lfs slot1");

    // R8: loopback ignores sdi
    do_reset(1'b0, 1'b0, 1'b0, 1'b1, 2'd0);
    sbit(1'b1, 1'b0, so);
    sframe(16'hFFFF, 16'h2222, "R8 loopback");
    sframe(16'h0000, 16'hDEAD, "R8 loopback");
    check(exp_q.size() == 0, "R8 loopback words delivered", exp_q.size(), 0);

    // R6: generated bit clock periods
    measure(2'd0, 8);
    measure(2'd1, 16);
    measure(2'd2, 32);
    measure(2'd3, 32);

    // R7: generated frame, short sync requested but long sync produced
    do_reset(1'b1, 1'b0, 1'b1, 1'b0, 2'd1);
    mframe(16'h6B3D, 16'hA0F5);
    do_reset(1'b1, 1'b0, 1'b0, 1'b0, 2'd0);
    mframe(16'h1C2D, 16'h5E6F);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule